// File: doc/BRIEF.md
# Serial Port Control and Status Register Block

This block is the software-visible register layer of a simple serial port. A host reaches it over a 32-bit register bus with single-cycle read and write strobes. It decodes the word index taken from the byte address with its two low bits dropped. It keeps the control registers, two status words, a test word and a set of baud-related scratch registers. It also raises one level interrupt.

Received characters come from the serializer through a valid/ready handshake into a one-entry holding register. A character is taken on a cycle where `rx_valid` and `rx_ready` are both high. `rx_ready` is low while the holding register is full, so the serializer must keep its character until the host empties the entry. A break condition travels on the same handshake, with `rx_break` set alongside `rx_valid`.

Characters to transmit leave as a one-cycle `tx_valid` strobe with `tx_data`. The strobe has no back-pressure: the serializer downstream must take every strobed byte.

Top module: `uart_regfile`

## Requirements
- R1: After power-on reset the reads are: control 1 (index 0x20) = 0x0001, control 2 (0x21) = 0x0004, control 3 (0x22) = 0x0700, status 1 (0x25) = 0x6040, status 2 (0x26) = 0x4028, test word (0x2D) = 0x0060, baud modulator (0x2A) = 0, baud count (0x2B) = 4, receive data (0x00) = 0x4000. `irq` is 0 and `rx_ready` is 1.
- R2: A write to control 2 with bit 0 clear performs a soft reset, and control 2 then reads back the written low 16 bits with bit 0 set. The soft reset does the following:
  - control 1 becomes 0;
  - control 3 becomes 0x0700;
  - the baud modulator becomes 0 and the baud count becomes 4;
  - the holding register is emptied and set to 0x4000;
  - FIFO control and the millisecond register keep their values.

  A write to control 2 with bit 0 set stores its low 16 bits and resets nothing.
- R3: A character accepted on the receive handshake is stored in the holding register and updates the flags:
  - status 1 bit 9 is set;
  - status 2 bit 0 is set;
  - test word bit 5 (RX-empty) is cleared;
  - `rx_ready` stays low until the entry is read.

  A character offered while the entry is full is not taken.
- R4: A break event accepted on the handshake stores 0x0800 (bit 11) in place of a character.
- R5: A read of index 0x00 returns the holding register. When the entry is full, the read also does the following:
  - bit 15 is set in the returned value;
  - the entry is emptied, so status 1 bit 9 and status 2 bit 0 clear and test bit 5 sets.

  A read while the entry is empty returns the value without bit 15 and changes nothing.
- R6: When a read of index 0x00 and a receive event fall in the same cycle, the read takes effect first. `rx_ready` is high in that cycle, and the new character is then stored with the entry full again.
- R7: `irq` = (status1 bit 9 AND control1 bit 9) OR (control1 bit 6 AND ((status1 bit 13 AND control1 bit 13) OR test bit 6)). Test bit 6 is always 1, so with control 1 bit 6 clear, the transmit-ready source never raises `irq`.
- R8: A write to index 0x10 while control 2 bit 2 is set strobes `tx_valid` for one cycle, starting the cycle after the write, with the low byte of the write data. Status 1 bit 13 reads 0 during that strobe cycle and 1 afterwards. With control 2 bit 2 clear, the write produces no strobe.
- R9: Writing ones to status 1 or status 2 leaves their readback unchanged, because this block has no source for their clearable event bits.
- R10: FIFO control (0x24), control 3, baud modulator and millisecond register (0x2C) keep the low 16 bits of a write. A write to the baud increment index (0x29) lands in the baud count (read at 0x2B). Reads of 0x29 and of control 4 (0x23) return 0.
- R11: Writes to the test word and to control 4 have no effect, and unknown indexes read 0.
- R12: Control 1 keeps the low 16 bits of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low power-on reset |
| bus_rd | input | 1 | read strobe; side effects at the closing edge |
| bus_wr | input | 1 | write strobe |
| bus_addr | input | ADDR_W | byte address; bits [1:0] ignored |
| bus_wdata | input | DATA_W | write data |
| bus_rdata | output | DATA_W | read data, valid in the strobe cycle |
| rx_valid | input | 1 | receive event offered |
| rx_ready | output | 1 | holding register can take the event |
| rx_data | input | BYTE_W | received character |
| rx_break | input | 1 | event is a break, not a character |
| tx_valid | output | 1 | one-cycle transmit strobe |
| tx_data | output | BYTE_W | byte to transmit |
| irq | output | 1 | level interrupt |

## Verification
The receive path is tried in several ways:
- a lone character, which shows the flags being set;
- a character offered while the entry is full, which shows that no overwrite happens;
- a break event, which shows the stored code;
- a read that falls in the same cycle as a new event, which shows the read-first ordering.

Transmit writes are made with the enable on and off, and status 1 is read in the cycle right after a write; this separates the one-cycle ready dip from a flag that stays low. The interrupt is stepped through each enable combination, so the masked receive term, the ignored transmit term and the empty-enable override each show up on their own. Soft reset is compared with a plain control 2 write, and registers that must keep their values are checked alongside those that must return to their reset values.

// File: rtl/uart_regs_pkg.sv
`timescale 1ns/1ps
package uart_regs_pkg;
  // word indexes (byte address >> 2)
  localparam int IX_RXD   = 'h00;
  localparam int IX_TXD   = 'h10;
  localparam int IX_CTL1  = 'h20;
  localparam int IX_CTL2  = 'h21;
  localparam int IX_CTL3  = 'h22;
  localparam int IX_CTL4  = 'h23;
  localparam int IX_FIFO  = 'h24;
  localparam int IX_STAT1 = 'h25;
  localparam int IX_STAT2 = 'h26;
  localparam int IX_BINC  = 'h29;
  localparam int IX_BMOD  = 'h2A;
  localparam int IX_BCNT  = 'h2B;
  localparam int IX_MSEC  = 'h2C;
  localparam int IX_TEST  = 'h2D;

  // bit positions
  localparam int S1_RXIDLE = 6;
  localparam int S1_RXRDY  = 9;
  localparam int S1_TXRDY  = 13;
  localparam int S1_RTS    = 14;
  localparam int S2_RXDAT  = 0;
  localparam int S2_TXDONE = 3;
  localparam int S2_DCD    = 5;
  localparam int S2_TXFE   = 14;
  localparam int T_RXEMPTY = 5;
  localparam int T_TXEMPTY = 6;
  localparam int C1_ENABLE = 0;
  localparam int C1_TXMTEN = 6;
  localparam int C2_NRST   = 0;
  localparam int C2_RXEN   = 1;
  localparam int C2_TXEN   = 2;
  localparam int RD_CHRDY  = 15;
  localparam int RD_ERR    = 14;
  localparam int RD_BRK    = 11;

  // reset values (16-bit register view)
  localparam logic [15:0] SR_CTL3 = 16'h0700;
  localparam logic [15:0] SR_BCNT = 16'h0004;
  localparam logic [15:0] SR_RBUF = 16'h0001 << RD_ERR;
  localparam logic [15:0] PO_CTL1 = 16'h0001 << C1_ENABLE;
  localparam logic [15:0] PO_CTL2 = 16'h0001 << C2_TXEN;
endpackage

// File: rtl/uart_ctrl_regs.sv
`timescale 1ns/1ps
module uart_ctrl_regs
  import uart_regs_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_ctl1,
  input  logic             we_ctl2,
  input  logic             we_ctl3,
  input  logic             we_fifo,
  input  logic             we_bcnt,
  input  logic             we_bmod,
  input  logic             we_msec,
  input  logic [REG_W-1:0] wd,
  output logic             soft_rst,
  output logic [REG_W-1:0] ctl1,
  output logic [REG_W-1:0] ctl2,
  output logic [REG_W-1:0] ctl3,
  output logic [REG_W-1:0] fifo,
  output logic [REG_W-1:0] bcnt,
  output logic [REG_W-1:0] bmod,
  output logic [REG_W-1:0] msec
);
  localparam logic [REG_W-1:0] NRST_MASK = REG_W'(1) << C2_NRST;

  assign soft_rst = we_ctl2 && !wd[C2_NRST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl1 <= REG_W'(PO_CTL1);
      ctl2 <= REG_W'(PO_CTL2);
      ctl3 <= REG_W'(SR_CTL3);
      fifo <= '0;
      bcnt <= REG_W'(SR_BCNT);
      bmod <= '0;
      msec <= '0;
    end else begin
      if (soft_rst) begin
        ctl1 <= '0;
        ctl3 <= REG_W'(SR_CTL3);
        bcnt <= REG_W'(SR_BCNT);
        bmod <= '0;
      end else begin
        if (we_ctl1) ctl1 <= wd;
        if (we_ctl3) ctl3 <= wd;
        if (we_bcnt) bcnt <= wd;
        if (we_bmod) bmod <= wd;
      end
      if (we_ctl2) ctl2 <= wd | NRST_MASK;
      if (we_fifo) fifo <= wd;
      if (we_msec) msec <= wd;
    end
  end

  // R2
  soft_rst_values_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (ctl1 == '0 && ctl3 == REG_W'(SR_CTL3) && bmod == '0 &&
                  bcnt == REG_W'(SR_BCNT) && ctl2[C2_NRST]));
  // R10
  bmod_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_bmod && !soft_rst) |=> bmod == $past(wd));
  // R2
  fifo_survives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst && !we_fifo) |=> $stable(fifo));
endmodule

// File: rtl/uart_rx_hold.sv
`timescale 1ns/1ps
module uart_rx_hold
  import uart_regs_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              rd_take,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_break,
  output logic              rx_ready,
  output logic              rx_full,
  output logic [REG_W-1:0]  rx_word
);
  localparam logic [REG_W-1:0] BRK_CODE = REG_W'(1) << RD_BRK;
  logic accept;

  // read-first: a read that empties the entry frees it in the same cycle
  assign rx_ready = (!rx_full || rd_take) && !soft_rst;
  assign accept   = rx_valid && rx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_full <= 1'b0;
      rx_word <= REG_W'(SR_RBUF);
    end else if (soft_rst) begin
      rx_full <= 1'b0;
      rx_word <= REG_W'(SR_RBUF);
    end else begin
      if (rd_take) rx_full <= 1'b0;
      if (accept) begin
        rx_full <= 1'b1;
        rx_word <= rx_break ? BRK_CODE : REG_W'(rx_data);
      end
    end
  end

  // R3
  no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !rd_take && !soft_rst) |=> ($stable(rx_word) && rx_full));
  // R5
  read_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_take && !rx_valid) |=> !rx_full);
  // R6
  read_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_take && rx_valid && !soft_rst) |=> rx_full);
endmodule

// File: rtl/uart_tx_strobe.sv
`timescale 1ns/1ps
module uart_tx_strobe #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_tx,
  input  logic              tx_en,
  input  logic [BYTE_W-1:0] wbyte,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_rdy
);
  logic fire;
  assign fire   = wr_tx && tx_en;
  assign tx_rdy = !tx_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      tx_valid <= fire;
      if (fire) tx_data <= wbyte;
    end
  end

  // R8
  tx_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (tx_valid && tx_data == $past(wbyte)));
  // R8
  tx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !tx_valid);
endmodule

// File: rtl/uart_regfile.sv
`timescale 1ns/1ps
module uart_regfile
  import uart_regs_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int REG_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_break,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic              irq
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] widx;
  logic [REG_W-1:0] wd;
  logic             unused_bits;
  assign widx        = bus_addr[ADDR_W-1:2];
  assign wd          = bus_wdata[REG_W-1:0];
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:REG_W]};

  function automatic logic hit(input logic [IDX_W-1:0] a, input int ix);
    return a == IDX_W'(ix);
  endfunction

  logic soft_rst, rx_full, tx_rdy;
  logic [REG_W-1:0] ctl1, ctl2, ctl3, fifo, bcnt, bmod, msec, rx_word;

  uart_ctrl_regs #(.REG_W(REG_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .we_ctl1(bus_wr && hit(widx, IX_CTL1)),
    .we_ctl2(bus_wr && hit(widx, IX_CTL2)),
    .we_ctl3(bus_wr && hit(widx, IX_CTL3)),
    .we_fifo(bus_wr && hit(widx, IX_FIFO)),
    .we_bcnt(bus_wr && hit(widx, IX_BINC)),
    .we_bmod(bus_wr && hit(widx, IX_BMOD)),
    .we_msec(bus_wr && hit(widx, IX_MSEC)),
    .wd(wd), .soft_rst(soft_rst),
    .ctl1(ctl1), .ctl2(ctl2), .ctl3(ctl3), .fifo(fifo),
    .bcnt(bcnt), .bmod(bmod), .msec(msec)
  );

  uart_rx_hold #(.BYTE_W(BYTE_W), .REG_W(REG_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .rd_take(bus_rd && hit(widx, IX_RXD)),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_break(rx_break),
    .rx_ready(rx_ready), .rx_full(rx_full), .rx_word(rx_word)
  );

  uart_tx_strobe #(.BYTE_W(BYTE_W)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .wr_tx(bus_wr && hit(widx, IX_TXD)), .tx_en(ctl2[C2_TXEN]),
    .wbyte(bus_wdata[BYTE_W-1:0]),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_rdy(tx_rdy)
  );

  // status assembly: no transmit queue, so TX-empty is always set
  logic             tx_empty;
  logic [REG_W-1:0] stat1, stat2, testw, rxd_view;
  assign tx_empty = 1'b1;
  always_comb begin
    stat1 = '0;
    stat1[S1_RXIDLE] = 1'b1;
    stat1[S1_RXRDY]  = rx_full;
    stat1[S1_TXRDY]  = tx_rdy;
    stat1[S1_RTS]    = 1'b1;
    stat2 = '0;
    stat2[S2_RXDAT]  = rx_full;
    stat2[S2_TXDONE] = 1'b1;
    stat2[S2_DCD]    = 1'b1;
    stat2[S2_TXFE]   = 1'b1;
    testw = '0;
    testw[T_RXEMPTY] = !rx_full;
    testw[T_TXEMPTY] = tx_empty;
    rxd_view = rx_word;
    rxd_view[RD_CHRDY] = rx_word[RD_CHRDY] | rx_full;
  end

  logic [REG_W-1:0] rd16;
  always_comb begin
    case (widx)
      IDX_W'(IX_RXD):   rd16 = rxd_view;
      IDX_W'(IX_CTL1):  rd16 = ctl1;
      IDX_W'(IX_CTL2):  rd16 = ctl2;
      IDX_W'(IX_CTL3):  rd16 = ctl3;
      IDX_W'(IX_FIFO):  rd16 = fifo;
      IDX_W'(IX_STAT1): rd16 = stat1;
      IDX_W'(IX_STAT2): rd16 = stat2;
      IDX_W'(IX_BMOD):  rd16 = bmod;
      IDX_W'(IX_BCNT):  rd16 = bcnt;
      IDX_W'(IX_MSEC):  rd16 = msec;
      IDX_W'(IX_TEST):  rd16 = testw;
      default:          rd16 = '0;
    endcase
  end
  assign bus_rdata = DATA_W'(rd16);

  logic rx_term, tx_term;
  assign rx_term = stat1[S1_RXRDY] & ctl1[S1_RXRDY];
  assign tx_term = stat1[S1_TXRDY] & ctl1[S1_TXRDY];
  assign irq = rx_term | (ctl1[C1_TXMTEN] & (tx_term | testw[T_TXEMPTY]));

  // R7
  txmt_forces_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl1[C1_TXMTEN] |-> irq);
  // R7
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl1[C1_TXMTEN] && !rx_full) |-> !irq);
  // R3
  full_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !bus_rd) |-> !rx_ready);
endmodule

// File: tb/uart_regfile_bench.sv
`timescale 1ns/1ps
module uart_regfile_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_valid = 1'b0, rx_break = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready, tx_valid, irq;
  logic [7:0]  tx_data;

  always #2.5 clk = ~clk;

  uart_regfile u_uart_regfile (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_break(rx_break), .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
  );

  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] rd_q[$];
  string       rdtag_q[$];
  logic [7:0]  tx_q[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: compares reads and transmit strobes as they appear
  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_rd) begin
        if (rd_q.size() == 0) chk("read with no expectation", 1, 0);
        else chk(rdtag_q.pop_front(), bus_rdata, rd_q.pop_front());
      end
      if (tx_valid) begin
        if (tx_q.size() == 0) chk("R8 unexpected tx strobe", {24'h0, tx_data}, 32'hFFFF_FFFF);
        else chk("R8 tx byte", {24'h0, tx_data}, {24'h0, tx_q.pop_front()});
      end
    end
  end

  task automatic bwrite(int idx, logic [31:0] d);
    bus_wr = 1; bus_addr = 12'(idx << 2); bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic bread(int idx, logic [31:0] exp, string tag);
    rd_q.push_back(exp); rdtag_q.push_back(tag);
    bus_rd = 1; bus_addr = 12'(idx << 2);
    @(posedge clk); #1;
    bus_rd = 0;
  endtask

  task automatic rx_send(logic [7:0] b, logic brk);
    rx_valid = 1; rx_data = b; rx_break = brk;
    @(posedge clk); #1;
    rx_valid = 0; rx_break = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk("R1 irq", {31'h0, irq}, 0);
    chk("R1 rx_ready", {31'h0, rx_ready}, 1);
    bread('h20, 32'h0001, "R1 ctl1");
    bread('h21, 32'h0004, "R1 ctl2");
    bread('h22, 32'h0700, "R1 ctl3");
    bread('h25, 32'h6040, "R1 stat1");
    bread('h26, 32'h4028, "R1 stat2");
    bread('h2D, 32'h0060, "R1 test");
    bread('h2A, 32'h0000, "R1 bmod");
    bread('h2B, 32'h0004, "R1 bcnt");
    bread('h00, 32'h4000, "R1 rxd");
    // R10 scratch registers
    bwrite('h24, 32'hABCD1234); bread('h24, 32'h1234, "R10 fifo");
    bwrite('h22, 32'h00015A5A); bread('h22, 32'h5A5A, "R10 ctl3");
    bwrite('h2A, 32'h0077);     bread('h2A, 32'h0077, "R10 bmod");
    bwrite('h2C, 32'hF00003E8); bread('h2C, 32'h03E8, "R10 msec");
    bwrite('h29, 32'h00010010); bread('h2B, 32'h0010, "R10 binc->bcnt");
    bread('h29, 32'h0, "R10 binc reads 0");
    bread('h23, 32'h0, "R10 ctl4 reads 0");
    // R11 ignored writes, unknown index
    bwrite('h2D, 32'hFFFF); bread('h2D, 32'h0060, "R11 test write ignored");
    bwrite('h23, 32'hFFFF); bread('h23, 32'h0, "R11 ctl4 write ignored");
    bread('h05, 32'h0, "R11 unknown 0x05");
    bread('h3F, 32'h0, "R11 unknown 0x3F");
    // R9 status write-one-to-clear has no visible effect
    bwrite('h25, 32'hFFFF); bread('h25, 32'h6040, "R9 stat1");
    bwrite('h26, 32'hFFFF); bread('h26, 32'h4028, "R9 stat2");
    // R3 receive
    rx_send(8'h41, 0);
    chk("R3 rx_ready low when full", {31'h0, rx_ready}, 0);
    bread('h25, 32'h6240, "R3 stat1");
    bread('h26, 32'h4029, "R3 stat2");
    bread('h2D, 32'h0040, "R3 test");
    rx_send(8'h42, 0); // offered while full: dropped
    // R5 read
    bread('h00, 32'h8041, "R5 rxd full");
    bread('h00, 32'h0041, "R5 rxd empty");
    bread('h25, 32'h6040, "R5 stat1 cleared");
    bread('h2D, 32'h0060, "R5 test rx-empty");
    // R4 break
    rx_send(8'h55, 1);
    bread('h00, 32'h8800, "R4 break code");
    // R6 same-cycle read and receive
    rx_send(8'h11, 0);
    rd_q.push_back(32'h8011); rdtag_q.push_back("R6 read first");
    bus_rd = 1; bus_addr = 12'h000; rx_valid = 1; rx_data = 8'h22;
    #1 chk("R6 rx_ready during read", {31'h0, rx_ready}, 1);
    @(posedge clk); #1;
    bus_rd = 0; rx_valid = 0;
    bread('h00, 32'h8022, "R6 new byte stored");
    // R7 interrupt
    bwrite('h20, 32'h0200); chk("R7 rx enabled, empty", {31'h0, irq}, 0);
    rx_send(8'h33, 0);      chk("R7 rx enabled, full", {31'h0, irq}, 1);
    bread('h00, 32'h8033, "R7 drain");
    chk("R7 after drain", {31'h0, irq}, 0);
    bwrite('h20, 32'h2000); chk("R7 tx-ready source dropped", {31'h0, irq}, 0);
    bwrite('h20, 32'h0040); chk("R7 tx-empty enable", {31'h0, irq}, 1);
    // R12 control 1 width
    bwrite('h20, 32'h00018001); bread('h20, 32'h8001, "R12 ctl1");
    chk("R7 enables off", {31'h0, irq}, 0);
    // R8 transmit
    tx_q.push_back(8'h5A);
    bwrite('h10, 32'h0001235A);
    bread('h25, 32'h4040, "R8 tx-ready dip");
    bread('h25, 32'h6040, "R8 tx-ready back");
    bwrite('h21, 32'h0001);
    bwrite('h10, 32'h0077);
    bread('h25, 32'h6040, "R8 disabled write");
    bwrite('h21, 32'h0005);
    // R2 soft reset
    bwrite('h22, 32'h1234); bwrite('h2A, 32'h0005); bwrite('h20, 32'h0201);
    rx_send(8'h66, 0);
    bwrite('h21, 32'h0006);
    bread('h21, 32'h0007, "R2 ctl2 bit0 forced");
    bread('h20, 32'h0000, "R2 ctl1");
    bread('h22, 32'h0700, "R2 ctl3");
    bread('h2A, 32'h0000, "R2 bmod");
    bread('h2B, 32'h0004, "R2 bcnt");
    bread('h25, 32'h6040, "R2 stat1");
    bread('h00, 32'h4000, "R2 rxd");
    bread('h24, 32'h1234, "R2 fifo kept");
    bread('h2C, 32'h03E8, "R2 msec kept");
    bwrite('h22, 32'h0099);
    bwrite('h21, 32'h00012345);
    bread('h21, 32'h2345, "R2 plain ctl2 write");
    bread('h22, 32'h0099, "R2 no reset on bit0 set");
    repeat (4) @(posedge clk);
    chk("R8 all tx seen", tx_q.size(), 0);
    chk("read queue drained", rd_q.size(), 0);
    finish_run();
  end
endmodule